// File: doc/BRIEF.md
# Mode-Aware Watchdog and Wake-Up Timer

This block is a single counter that serves two jobs depending on the operating mode of the system. It advances only on cycles where a slow tick enable is high. In RUN mode it is a CPU watchdog: once software has armed the reset function, it must issue a restart write before the counter reaches its terminal count, otherwise the block produces a one-cycle system reset request. In STOP mode the watchdog function freezes, keeping its count, and the counter can instead produce a periodic wake-up interrupt pulse.

Software sees one control register on a simple write-strobe bus with a combinational read port. The register holds a restart command, a reset arm bit that can only be set and never cleared by software, an interrupt enable and a period select. The period select picks a short or a long terminal count, both powers of two set by parameters. When neither the reset arm bit nor the interrupt enable is set, the counter is held at zero and no event can be produced.

Top module: `mode_watchdog`

## Requirements
- R1: After reset the read port returns 0 and neither the reset request nor the interrupt output is high.
- R2: Control register layout: bit 3 restart, bit 2 reset arm, bit 1 interrupt enable, bit 0 period select. Bits 2..0 read back as written (subject to R3); bit 3 and bits 7..4 always read 0 and writes to bits 7..4 are ignored.
- R3: The reset arm bit, once set by a write of 1, stays set: writing 0 to it has no effect until the next reset.
- R4: With reset arm and interrupt enable both clear, the counter is held at zero and no reset request or interrupt is ever produced, however many ticks arrive.
- R5: In RUN mode with reset arm set, a reset request pulse of exactly one clock cycle follows the tick that completes 2^SHORT_LOG ticks (period select 0) or 2^LONG_LOG ticks (period select 1) since the last counter clear; the counter then starts again from zero.
- R6: A write with bit 3 set clears the counter and starts a fresh period; a write with bit 3 clear leaves the count untouched.
- R7: A restart write in the same clock cycle as the terminal tick wins: no reset request is produced and a full new period begins.
- R8: In STOP mode the watchdog count is frozen (no ticks counted unless the interrupt enable is set) and no reset request is ever produced; on return to RUN counting resumes from the held value.
- R9: In STOP mode with interrupt enable set, a one-cycle interrupt pulse follows every completed period of the selected length, the counter restarting from zero after each; the interrupt is never produced in RUN mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow time-base enable, one count per high cycle |
| stopMode | input | 1 | 1 = STOP mode, 0 = RUN mode |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | DATA_W | Control register write data |
| rdData | output | DATA_W | Control register read value |
| rstReq | output | 1 | One-cycle system reset request |
| irqOut | output | 1 | One-cycle wake-up interrupt pulse |

## Verification
The bench counts ticks between events over both period lengths and in both modes, so a counter that is off by one, wraps at the wrong value or fails to restart after an event shows up as a pulse at the wrong tick or with the wrong count. It puts a restart write on the exact terminal tick, where a design giving the terminal count priority would emit a reset. It writes 0 to the armed reset bit, where a design treating the bit as ordinary storage would disarm the watchdog, and parks the counter in STOP mode mid-period, where a design that cleared or kept counting would fire early or late after returning to RUN.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // control register bit positions
  localparam int unsigned BIT_RESTART = 3;
  localparam int unsigned BIT_ARM     = 2;
  localparam int unsigned BIT_IRQEN   = 1;
  localparam int unsigned BIT_PSEL    = 0;

  // strobes from the control to the counter datapath
  typedef struct packed {
    logic clear;
    logic advance;
  } cntStrobe_t;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int unsigned SHORT_LOG = 10,
  parameter int unsigned LONG_LOG  = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  cntStrobe_t strobe,
  input  logic       periodSel,
  output logic       nearEnd
);

  localparam int unsigned CNT_W = LONG_LOG;
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((64'd1 << SHORT_LOG) - 64'd1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'((64'd1 << LONG_LOG) - 64'd1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastValue;

  assign lastValue = periodSel ? LONG_LAST : SHORT_LAST;
  // >= so that switching to the short period mid-count still ends promptly
  assign nearEnd   = (count >= lastValue);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.clear) begin
      count <= '0;
    end else if (strobe.advance) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              stopMode,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              nearEnd,
  output cntStrobe_t        strobe,
  output logic              periodSel,
  output logic [DATA_W-1:0] rdData,
  output logic              rstReq,
  output logic              irqOut
);

  logic armReg;
  logic irqEnReg;
  logic pselReg;
  logic restartHit;
  logic enabled;
  logic counting;
  logic wrapHit;
  logic wrUnused;

  assign wrUnused   = ^wrData[DATA_W-1:BIT_RESTART+1];
  assign restartHit = wrEn & wrData[BIT_RESTART];
  assign enabled    = armReg | irqEnReg;
  // RUN counts for the watchdog, STOP counts only for wake-up
  assign counting   = tick & (stopMode ? irqEnReg : armReg);
  assign wrapHit    = counting & nearEnd;

  always_comb begin
    strobe.clear   = restartHit | wrapHit | ~enabled;
    strobe.advance = counting & ~strobe.clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armReg   <= 1'b0;
      irqEnReg <= 1'b0;
      pselReg  <= 1'b0;
    end else if (wrEn) begin
      armReg   <= armReg | wrData[BIT_ARM];
      irqEnReg <= wrData[BIT_IRQEN];
      pselReg  <= wrData[BIT_PSEL];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReq <= 1'b0;
      irqOut <= 1'b0;
    end else begin
      rstReq <= wrapHit & ~stopMode & ~restartHit;
      irqOut <= wrapHit &  stopMode & ~restartHit;
    end
  end

  always_comb begin
    rdData            = '0;
    rdData[BIT_ARM]   = armReg;
    rdData[BIT_IRQEN] = irqEnReg;
    rdData[BIT_PSEL]  = pselReg;
  end

  assign periodSel = pselReg;

endmodule

// File: rtl/mode_watchdog.sv
module mode_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SHORT_LOG = 10,
  parameter int unsigned LONG_LOG  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              stopMode,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rstReq,
  output logic              irqOut
);

  cntStrobe_t strobe;
  logic       periodSel;
  logic       nearEnd;

  wdt_ctrl #(
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .stopMode (stopMode),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .nearEnd  (nearEnd),
    .strobe   (strobe),
    .periodSel(periodSel),
    .rdData   (rdData),
    .rstReq   (rstReq),
    .irqOut   (irqOut)
  );

  wdt_datapath #(
    .SHORT_LOG(SHORT_LOG),
    .LONG_LOG (LONG_LOG)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .periodSel(periodSel),
    .nearEnd  (nearEnd)
  );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopMode,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              rstReq,
  input logic              irqOut
);

  // R2
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:3] == '0);

  // R3
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[2] |=> rdData[2]);

  // R4
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[2:1] == 2'b00) |=> (!rstReq && !irqOut));

  // R5
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  // R7
  restart_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[3]) |=> (!rstReq && !irqOut));

  // R8
  no_rst_in_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopMode |=> !rstReq);

  // R9
  no_irq_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stopMode || !rdData[1]) |=> !irqOut);

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |=> !irqOut);

endmodule

bind mode_watchdog wdt_checker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .stopMode(stopMode),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .rstReq  (rstReq),
  .irqOut  (irqOut)
);

// File: tb/test_mode_watchdog.sv
`timescale 1ns/1ps
module test_mode_watchdog;

  localparam int SHORT_LOG = 3;
  localparam int LONG_LOG  = 5;
  localparam int SHORT_P   = 1 << SHORT_LOG;
  localparam int LONG_P    = 1 << LONG_LOG;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       stopMode = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       rstReq;
  logic       irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  int rstCnt, rstLast, irqCnt, irqLast;

  always #2 clk = ~clk;

  mode_watchdog #(
    .DATA_W(8), .SHORT_LOG(SHORT_LOG), .LONG_LOG(LONG_LOG)
  ) i_mode_watchdog (
    .clk(clk), .rstN(rstN), .tick(tick), .stopMode(stopMode),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .rstReq(rstReq), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  // n consecutive ticks; pulses recorded by tick index (1-based)
  task automatic runTicks(input int n);
    rstCnt = 0; rstLast = 0; irqCnt = 0; irqLast = 0;
    @(negedge clk);
    tick = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (rstReq) begin rstCnt++; rstLast = i; end
      if (irqOut) begin irqCnt++; irqLast = i; end
      if (i == n) tick = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(rdData == 8'h00, "R1 read", rdData, 0);
    check(!rstReq && !irqOut, "R1 outputs", {rstReq, irqOut}, 0);

    // R2 sweep of writes with the arm bit clear
    for (int v = 0; v < 256; v += 17) begin
      logic [7:0] w;
      w = 8'(v) & 8'hFB;
      writeReg(w);
      check(rdData == (w & 8'h03), "R2 readback", rdData, w & 8'h03);
    end

    // R4 disabled
    writeReg(8'h00);
    runTicks(100);
    check(rstCnt == 0 && irqCnt == 0, "R4 disabled", rstCnt + irqCnt, 0);
    stopMode = 1'b1;
    runTicks(100);
    check(rstCnt == 0 && irqCnt == 0, "R4 disabled stop", rstCnt + irqCnt, 0);
    stopMode = 1'b0;

    // R9 interrupt enabled in RUN: no events
    writeReg(8'h0A);
    runTicks(3 * SHORT_P);
    check(irqCnt == 0 && rstCnt == 0, "R9 no irq in RUN", irqCnt + rstCnt, 0);
    // R9 wake-ups in STOP, short then long
    stopMode = 1'b1;
    runTicks(3 * SHORT_P);
    check(irqCnt == 3, "R9 short count", irqCnt, 3);
    check(irqLast == 3 * SHORT_P, "R9 short last", irqLast, 3 * SHORT_P);
    check(rstCnt == 0, "R8 no rst in STOP", rstCnt, 0);
    writeReg(8'h0B);
    runTicks(2 * LONG_P);
    check(irqCnt == 2 && irqLast == 2 * LONG_P, "R9 long", irqLast, 2 * LONG_P);
    stopMode = 1'b0;

    // R5 arm, short period
    writeReg(8'h0C);
    check(rdData == 8'h04, "R2 restart reads 0", rdData, 4);
    runTicks(SHORT_P);
    check(rstCnt == 1 && rstLast == SHORT_P, "R5 short first", rstLast, SHORT_P);
    @(negedge clk);
    check(!rstReq, "R5 one-cycle pulse", rstReq, 0);
    runTicks(3 * SHORT_P);
    check(rstCnt == 3 && rstLast == 3 * SHORT_P, "R5 short repeat", rstCnt, 3);
    check(irqCnt == 0, "R9 no irq in RUN armed", irqCnt, 0);

    // R3 writing 0 does not disarm
    writeReg(8'h00);
    check(rdData[2] == 1'b1, "R3 sticky arm", rdData[2], 1);
    runTicks(SHORT_P);
    check(rstCnt == 1 && rstLast == SHORT_P, "R3 still armed", rstLast, SHORT_P);

    // R5 long period
    writeReg(8'h0D);
    runTicks(LONG_P);
    check(rstCnt == 1 && rstLast == LONG_P, "R5 long", rstLast, LONG_P);

    // R6 restart mid period
    runTicks(20);
    check(rstCnt == 0, "R6 pre", rstCnt, 0);
    writeReg(8'h0D);
    runTicks(LONG_P - 1);
    check(rstCnt == 0, "R6 restart extends", rstCnt, 0);
    runTicks(1);
    check(rstCnt == 1, "R6 ends after full period", rstCnt, 1);
    // R6 write without bit 3 keeps count
    runTicks(20);
    writeReg(8'h05);
    runTicks(LONG_P - 20);
    check(rstCnt == 1 && rstLast == LONG_P - 20, "R6 no restart", rstLast, LONG_P - 20);

    // R7 restart on the terminal tick
    runTicks(LONG_P - 1);
    @(negedge clk);
    tick = 1'b1; wrEn = 1'b1; wrData = 8'h0D;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0; wrData = '0;
    check(!rstReq, "R7 restart wins", rstReq, 0);
    runTicks(LONG_P);
    check(rstCnt == 1 && rstLast == LONG_P, "R7 full new period", rstLast, LONG_P);

    // R8 STOP freezes count
    runTicks(20);
    stopMode = 1'b1;
    runTicks(3 * LONG_P);
    check(rstCnt == 0 && irqCnt == 0, "R8 frozen in STOP", rstCnt + irqCnt, 0);
    stopMode = 1'b0;
    runTicks(LONG_P - 20);
    check(rstCnt == 1 && rstLast == LONG_P - 20, "R8 resumes", rstLast, LONG_P - 20);

    // R9 both enabled: mode picks the event
    writeReg(8'h0F);
    stopMode = 1'b1;
    runTicks(LONG_P);
    check(irqCnt == 1 && rstCnt == 0, "R9 irq in STOP armed", irqCnt, 1);
    stopMode = 1'b0;
    runTicks(LONG_P);
    check(rstCnt == 1 && irqCnt == 0, "R5 rst in RUN both", rstCnt, 1);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule